// File: doc/BRIEF.md
# Flash Program/Erase Guard

This block stands between the processor's flash control registers and the flash array's program and erase controls. Software writes a control register that holds a master write-enable bit and the program and erase request bits, plus a mask register with one erase-enable bit for each flash block. The block turns these into registered program-active, erase-active and per-block erase-enable outputs.

Three layers of protection sit between the register state and the outputs. A synchronous reset, or any indication of a low-power mode (subactive, subsleep or standby), aborts any operation and clears every control bit, the block mask and the error flag. Without the write-enable bit, the request bits have no effect. While an operation is running, the block watches for a flash read, a non-reset exception entry or a sleep instruction. Any of these sets a sticky error flag and aborts the operation at once. Only reset or low-power entry clears the flag.

Top module: `flash_guard`

## Requirements
- R1: A synchronous active-high `rst` clears `prog_active`, `erase_active`, `blk_erase_en`, `err_flag` and `reg_rdata`, and all control and mask bits, on the next clock edge.
- R2: Any of `pm_subactive`, `pm_subsleep` or `pm_standby` high at a clock edge aborts the operation in progress and clears the control bits, the block mask and the error flag on that edge.
- R3: A control write (`reg_addr`=0) with the write-enable bit (bit 0) clear never asserts `prog_active` or `erase_active`, whatever the program bit (bit 1) and erase bit (bit 2) hold.
- R4: A control write with bit 0 set and exactly one of bit 1 (program) or bit 2 (erase) set asserts `prog_active` or `erase_active` on the clock edge that takes the write. Clearing the bit deasserts the output on the same kind of edge.
- R5: A control write that has both bit 1 and bit 2 set is ignored. The control register and the outputs keep their previous values.
- R6: `blk_erase_en[i]` is high exactly when erase mode is active, mask bit i (written at `reg_addr`=1) is set, and no error is latched. A mask of all zeros holds every enable low, even with `erase_active` high.
- R7: A `bus_rd` with `bus_addr` inside [FLASH_BASE, FLASH_BASE+FLASH_SIZE) while an operation is active sets `err_flag` and drops every mode output on the next edge. Reads outside the range, or reads made while idle, leave the flag clear.
- R8: An `exc_entry` pulse during an operation sets `err_flag` and aborts the operation, unless `exc_is_reset` is high with it. An exception while idle has no effect.
- R9: A `sleep_exec` pulse during an operation sets `err_flag` and aborts the operation. A sleep while idle has no effect.
- R10: `err_flag` is sticky. Register writes do not clear it. While it is set, `prog_active`, `erase_active` and `blk_erase_en` stay low even if the control bits are set again.
- R11: A `reg_rd` loads `reg_rdata` on the next edge with the selected register: address 0 gives {erase,prog,swe} in bits 2..0, address 1 gives the mask, and address 2 gives the error flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 block mask, 2 status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| pm_subactive | input | 1 | Subactive mode entry |
| pm_subsleep | input | 1 | Subsleep mode entry |
| pm_standby | input | 1 | Standby mode entry |
| exc_entry | input | 1 | Exception-entry strobe |
| exc_is_reset | input | 1 | Marks the exception as a reset |
| sleep_exec | input | 1 | Sleep-instruction strobe |
| bus_rd | input | 1 | Bus read strobe for the monitor |
| bus_addr | input | ADDR_W | Bus read address |
| prog_active | output | 1 | Program mode active |
| erase_active | output | 1 | Erase mode active |
| blk_erase_en | output | NUM_BLK | Per-block erase enables |
| err_flag | output | 1 | Sticky error-protection flag |

## Verification
Every result of this block comes from a single register stage. A write, a trap event or a low-power pulse that is present at edge N shows up on the mode outputs, the block enables and the error flag directly after edge N. A read strobe at edge N also shows up in `reg_rdata` at that point. The bench drives each stimulus at a falling edge. A reference model then computes the state that edge N must produce, and the bench queues it just after the rising edge. The monitor pops that entry at the next falling edge and compares it while every output is stable. As a result, each expectation is checked exactly one edge after its cause and never before.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [1:0] {
    RSEL_CTRL = 2'd0,
    RSEL_MASK = 2'd1,
    RSEL_STAT = 2'd2
  } rsel_e;

  // control register bit positions (software-visible encoding)
  localparam int CB_SWE   = 0;
  localparam int CB_PROG  = 1;
  localparam int CB_ERASE = 2;

  // status register bit position
  localparam int SB_ERR = 0;

  typedef struct packed {
    logic erase;
    logic prog;
    logic swe;
  } ctrl_t;

endpackage

// File: rtl/fg_addr_window.sv
module fg_addr_window #(
  parameter int ADDR_W     = 16,
  parameter int FLASH_BASE = 0,
  parameter int FLASH_SIZE = 32768
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int            EW   = ADDR_W + 1;
  localparam logic [EW-1:0] LO   = EW'(FLASH_BASE);
  localparam logic [EW-1:0] HI   = EW'(FLASH_BASE + FLASH_SIZE);

  logic [EW-1:0] ext;

  always_comb begin
    ext = {1'b0, addr};
    hit = (ext >= LO) && (ext < HI);
  end
endmodule

// File: rtl/fg_sw_regs.sv
module fg_sw_regs
  import flash_guard_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_BLK = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               wr,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  output ctrl_t              ctrl_q,
  output ctrl_t              ctrl_nxt,
  output logic [NUM_BLK-1:0] mask_q,
  output logic [NUM_BLK-1:0] mask_nxt
);
  logic both_req;

  always_comb begin
    both_req = wdata[CB_PROG] & wdata[CB_ERASE];
    ctrl_nxt = ctrl_q;
    mask_nxt = mask_q;
    if (clr) begin
      ctrl_nxt = '0;
      mask_nxt = '0;
    end else if (wr) begin
      case (rsel_e'(addr))
        RSEL_CTRL: begin
          if (!both_req) begin
            ctrl_nxt.swe   = wdata[CB_SWE];
            ctrl_nxt.prog  = wdata[CB_PROG];
            ctrl_nxt.erase = wdata[CB_ERASE];
          end
        end
        RSEL_MASK: mask_nxt = wdata[NUM_BLK-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      ctrl_q <= ctrl_nxt;
      mask_q <= mask_nxt;
    end
  end
endmodule

// File: rtl/fg_err_trap.sv
module fg_err_trap (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic busy,
  input  logic rd_hit,
  input  logic exc_entry,
  input  logic exc_is_reset,
  input  logic sleep_exec,
  output logic err_nxt,
  output logic err_q
);
  logic trap;

  always_comb begin
    trap    = busy & (rd_hit | (exc_entry & ~exc_is_reset) | sleep_exec);
    err_nxt = clr ? 1'b0 : (err_q | trap);
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_nxt;
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int NUM_BLK    = 8,
  parameter int FLASH_BASE = 0,
  parameter int FLASH_SIZE = 32768
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               pm_subactive,
  input  logic               pm_subsleep,
  input  logic               pm_standby,
  input  logic               exc_entry,
  input  logic               exc_is_reset,
  input  logic               sleep_exec,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  output logic               prog_active,
  output logic               erase_active,
  output logic [NUM_BLK-1:0] blk_erase_en,
  output logic               err_flag
);
  ctrl_t              ctrl_q, ctrl_nxt;
  logic [NUM_BLK-1:0] mask_q, mask_nxt;
  logic               lp_any, busy, win_hit, err_nxt, err_q;
  logic               prog_go, erase_go;
  logic [DATA_W-1:0]  rd_val;

  assign lp_any = pm_subactive | pm_subsleep | pm_standby;
  assign busy   = prog_active | erase_active;

  fg_addr_window #(
    .ADDR_W    (ADDR_W),
    .FLASH_BASE(FLASH_BASE),
    .FLASH_SIZE(FLASH_SIZE)
  ) u_win (
    .addr(bus_addr),
    .hit (win_hit)
  );

  fg_sw_regs #(
    .DATA_W (DATA_W),
    .NUM_BLK(NUM_BLK)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .clr     (lp_any),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .ctrl_q  (ctrl_q),
    .ctrl_nxt(ctrl_nxt),
    .mask_q  (mask_q),
    .mask_nxt(mask_nxt)
  );

  fg_err_trap u_trap (
    .clk         (clk),
    .rst         (rst),
    .clr         (lp_any),
    .busy        (busy),
    .rd_hit      (bus_rd & win_hit),
    .exc_entry   (exc_entry),
    .exc_is_reset(exc_is_reset),
    .sleep_exec  (sleep_exec),
    .err_nxt     (err_nxt),
    .err_q       (err_q)
  );

  assign err_flag = err_q;

  always_comb begin
    prog_go  = ctrl_nxt.swe & ctrl_nxt.prog  & ~err_nxt;
    erase_go = ctrl_nxt.swe & ctrl_nxt.erase & ~err_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_active  <= 1'b0;
      erase_active <= 1'b0;
    end else begin
      prog_active  <= prog_go;
      erase_active <= erase_go;
    end
  end

  for (genvar gi = 0; gi < NUM_BLK; gi++) begin : g_blk
    always_ff @(posedge clk) begin
      if (rst) blk_erase_en[gi] <= 1'b0;
      else     blk_erase_en[gi] <= erase_go & mask_nxt[gi];
    end
  end

  always_comb begin
    rd_val = '0;
    case (rsel_e'(reg_addr))
      RSEL_CTRL: begin
        rd_val[CB_SWE]   = ctrl_q.swe;
        rd_val[CB_PROG]  = ctrl_q.prog;
        rd_val[CB_ERASE] = ctrl_q.erase;
      end
      RSEL_MASK: rd_val[NUM_BLK-1:0] = mask_q;
      RSEL_STAT: rd_val[SB_ERR] = err_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int NUM_BLK = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               lp_any,
  input logic               bus_rd,
  input logic               hit,
  input logic               exc_entry,
  input logic               exc_is_reset,
  input logic               sleep_exec,
  input logic               swe,
  input logic               prog_active,
  input logic               erase_active,
  input logic [NUM_BLK-1:0] blk_erase_en,
  input logic               err_flag
);
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (!prog_active && !erase_active && !err_flag && blk_erase_en == '0)); // R1

  AST_LP_ABORT: assert property (@(posedge clk) disable iff (rst)
    lp_any |=> (!prog_active && !erase_active && !err_flag && blk_erase_en == '0)); // R2

  AST_MODE_NEEDS_SWE: assert property (@(posedge clk) disable iff (rst)
    (prog_active || erase_active) |-> swe); // R3

  AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(prog_active && erase_active)); // R5

  AST_BLK_NEEDS_ERASE: assert property (@(posedge clk) disable iff (rst)
    !erase_active |-> (blk_erase_en == '0)); // R6

  AST_READ_TRAP: assert property (@(posedge clk) disable iff (rst)
    ((prog_active || erase_active) && bus_rd && hit && !lp_any) |=> err_flag); // R7

  AST_EXC_TRAP: assert property (@(posedge clk) disable iff (rst)
    ((prog_active || erase_active) && exc_entry && !exc_is_reset && !lp_any) |=> err_flag); // R8

  AST_SLEEP_TRAP: assert property (@(posedge clk) disable iff (rst)
    ((prog_active || erase_active) && sleep_exec && !lp_any) |=> err_flag); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !lp_any) |=> err_flag); // R10

  AST_ERR_GATES: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (!prog_active && !erase_active && blk_erase_en == '0)); // R10
endmodule

bind flash_guard fg_checker #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .lp_any      (lp_any),
  .bus_rd      (bus_rd),
  .hit         (win_hit),
  .exc_entry   (exc_entry),
  .exc_is_reset(exc_is_reset),
  .sleep_exec  (sleep_exec),
  .swe         (ctrl_q.swe),
  .prog_active (prog_active),
  .erase_active(erase_active),
  .blk_erase_en(blk_erase_en),
  .err_flag    (err_flag)
);

// File: tb/flash_guard_tb.sv
`timescale 1ns/1ps
module flash_guard_tb;
  logic        clk = 1'b0;
  logic        rst, reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        pm_subactive, pm_subsleep, pm_standby;
  logic        exc_entry, exc_is_reset, sleep_exec, bus_rd;
  logic [15:0] bus_addr;
  logic        prog_active, erase_active, err_flag;
  logic [7:0]  blk_erase_en;

  always #4 clk = ~clk;

  flash_guard u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pm_subactive(pm_subactive), .pm_subsleep(pm_subsleep), .pm_standby(pm_standby),
    .exc_entry(exc_entry), .exc_is_reset(exc_is_reset), .sleep_exec(sleep_exec),
    .bus_rd(bus_rd), .bus_addr(bus_addr),
    .prog_active(prog_active), .erase_active(erase_active),
    .blk_erase_en(blk_erase_en), .err_flag(err_flag)
  );

  typedef struct {
    string      tag;
    logic       err, pa, ea;
    logic [7:0] blk, rd;
  } item_t;

  item_t q[$];
  int    n_cmp = 0, n_bad = 0;
  bit    done  = 0;

  // reference model state
  logic       m_swe, m_prog, m_erase, m_err, m_pa, m_ea;
  logic [7:0] m_mask, m_rd;

  task automatic idle_inputs();
    rst = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    pm_subactive = 0; pm_subsleep = 0; pm_standby = 0;
    exc_entry = 0; exc_is_reset = 0; sleep_exec = 0; bus_rd = 0; bus_addr = 0;
  endtask

  task automatic model_step();
    logic busy, hit, lp;
    busy = m_pa | m_ea;
    hit  = bus_addr < 16'h8000;
    lp   = pm_subactive | pm_subsleep | pm_standby;
    if (rst) begin
      m_swe = 0; m_prog = 0; m_erase = 0; m_mask = 0; m_err = 0; m_rd = 0;
    end else begin
      if (reg_rd) begin
        case (reg_addr)
          2'd0: m_rd = {5'b0, m_erase, m_prog, m_swe};
          2'd1: m_rd = m_mask;
          2'd2: m_rd = {7'b0, m_err};
          default: m_rd = 8'h00;
        endcase
      end
      if (lp) begin
        m_swe = 0; m_prog = 0; m_erase = 0; m_mask = 0; m_err = 0;
      end else begin
        if (busy && ((bus_rd && hit) || (exc_entry && !exc_is_reset) || sleep_exec))
          m_err = 1;
        if (reg_wr && reg_addr == 2'd0 && !(reg_wdata[1] && reg_wdata[2])) begin
          m_swe = reg_wdata[0]; m_prog = reg_wdata[1]; m_erase = reg_wdata[2];
        end
        if (reg_wr && reg_addr == 2'd1) m_mask = reg_wdata;
      end
    end
    m_pa = !rst && m_swe && m_prog  && !m_err;
    m_ea = !rst && m_swe && m_erase && !m_err;
  endtask

  // driver: inputs must already be set; runs one edge and queues the expectation
  task automatic cycle(string tag);
    item_t it;
    model_step();
    @(posedge clk);
    #1;
    it.tag = tag; it.err = m_err; it.pa = m_pa; it.ea = m_ea;
    it.blk = m_ea ? m_mask : 8'h00; it.rd = m_rd;
    q.push_back(it);
    idle_inputs();
  endtask

  task automatic do_rst(string tag);
    @(negedge clk); rst = 1; cycle(tag);
  endtask
  task automatic do_wr(string tag, logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d; cycle(tag);
  endtask
  task automatic do_rd(string tag, logic [1:0] a);
    @(negedge clk); reg_rd = 1; reg_addr = a; cycle(tag);
  endtask
  task automatic do_lp(string tag, int which);
    @(negedge clk);
    if (which == 0) pm_subactive = 1;
    else if (which == 1) pm_subsleep = 1;
    else pm_standby = 1;
    cycle(tag);
  endtask
  task automatic do_exc(string tag, logic is_rst);
    @(negedge clk); exc_entry = 1; exc_is_reset = is_rst; cycle(tag);
  endtask
  task automatic do_slp(string tag);
    @(negedge clk); sleep_exec = 1; cycle(tag);
  endtask
  task automatic do_bus(string tag, logic [15:0] a);
    @(negedge clk); bus_rd = 1; bus_addr = a; cycle(tag);
  endtask

  // monitor: compares one queued expectation per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (err_flag !== it.err || prog_active !== it.pa || erase_active !== it.ea ||
          blk_erase_en !== it.blk || reg_rdata !== it.rd) begin
        n_bad++;
        $display("FAIL %s: got err=%b pa=%b ea=%b blk=%h rd=%h expected err=%b pa=%b ea=%b blk=%h rd=%h",
                 it.tag, err_flag, prog_active, erase_active, blk_erase_en, reg_rdata,
                 it.err, it.pa, it.ea, it.blk, it.rd);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    m_swe = 0; m_prog = 0; m_erase = 0; m_mask = 0; m_err = 0; m_rd = 0; m_pa = 0; m_ea = 0;
    do_rst("R1 reset");
    do_rst("R1 reset held");
    do_rd("R1 reset state of status", 2'd2);

    do_wr("R3 program without write-enable", 2'd0, 8'h02);
    do_wr("R3 erase without write-enable", 2'd0, 8'h04);
    do_rd("R11 control readback", 2'd0);

    do_wr("R4 enter program", 2'd0, 8'h03);
    do_wr("R5 both bits ignored", 2'd0, 8'h07);
    do_rd("R5 control unchanged", 2'd0);
    do_bus("R7 read outside range", 16'hF000);
    do_wr("R4 leave program", 2'd0, 8'h01);

    do_wr("R11 mask write", 2'd1, 8'hA5);
    do_rd("R11 mask readback", 2'd1);
    do_wr("R6 erase with mask", 2'd0, 8'h05);
    do_slp("R9 sleep during erase");
    do_wr("R10 rewrite while error", 2'd0, 8'h03);
    do_rd("R10 status shows error", 2'd2);
    do_rd("R10 control bits kept", 2'd0);

    do_lp("R2 subsleep clears", 1);
    do_rd("R2 status cleared", 2'd2);
    do_rd("R2 mask cleared", 2'd1);
    do_wr("R6 erase with zero mask", 2'd0, 8'h05);
    do_exc("R8 reset exception ignored", 1'b1);
    do_exc("R8 exception during erase", 1'b0);

    do_lp("R2 standby clears", 2);
    do_wr("R4 program again", 2'd0, 8'h03);
    do_bus("R7 flash read during program", 16'h1234);
    do_lp("R2 subactive clears", 0);

    do_slp("R9 sleep while idle");
    do_exc("R8 exception while idle", 1'b0);
    do_bus("R7 flash read while idle", 16'h0010);
    do_rd("R9 status still clear", 2'd2);

    do_wr("R6 mask single block", 2'd1, 8'h80);
    do_wr("R6 erase single block", 2'd0, 8'h05);
    do_wr("R1 prepare program", 2'd0, 8'h03);
    do_rst("R1 reset during program");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule